// File: doc/BRIEF.md
# PCI INTx to ISA IRQ Router

This block connects four level-sensitive PCI interrupt pins to a bank of sixteen ISA interrupt request lines. Each pin has its own byte-wide route register, and software programs it at run time. A value below 16 selects the ISA line that the pin drives. A value of 16 or more disconnects the pin, and its level is then ignored. Several pins may be steered to the same ISA line. That line then behaves as a wired-OR: it stays high while at least one of the pins routed to it is high.

Internally the router keeps a pin-by-IRQ level matrix. A bit is set when a pin is asserted and currently routed to that IRQ. A change of level on a pin updates only that pin's bit under its current route. Any configuration write that lands on one or more route bytes clears the whole matrix in the following cycle and rebuilds it from the live pin levels. This removes stale contributions when a pin moves while asserted. The route bytes are reached through a small byte-addressed port. A write carries up to four bytes at consecutive addresses. The block also reports, for each pin, whether it is enabled and which IRQ it selects.

Top module: `intx_irq_router`

## Requirements
- R1: After reset every route byte reads 0x80, every pin reports disabled, all ISA outputs are low, and the read data is 0x00.
- R2: Route bytes sit at byte addresses 0x60 (pin A, pirq_i[0]) through 0x63 (pin D, pirq_i[3]). A write with cfg_we stores cfg_wdata[8k+7:8k] at address cfg_addr+k, for each k below cfg_wlen (1 to 4). Bytes at any other address are discarded, and cfg_wlen of 0 writes nothing.
- R3: A read with cfg_re returns the route byte at cfg_addr on cfg_rdata after the next clock edge, or 0x00 for an address outside 0x60..0x63. cfg_rdata holds its value until the next read.
- R4: irq_o[n] is high while any pin routed to n is high. When one of two pins sharing n drops, n stays high until the last one drops.
- R5: A pin level change sampled at a clock edge shows on irq_o right after that edge. irq_o changes only after such a change or after a route rebuild.
- R6: A route value of 16 or greater (for example 16 or 0x80) disables the pin, and its level then has no effect on irq_o. The value 15 is a valid route to irq_o[15].
- R7: A write that stores into any route byte rebuilds every output from the current pin levels at the second clock edge after the write is presented. A pin rerouted while asserted drops its old IRQ and raises its new one at that edge, and never drives two IRQs at once.
- R8: route_en_o[p] is 1 exactly when pin p's route byte is below 16. route_irq_o[4p+3:4p] then holds the low four bits of that byte, and it holds 0 when the pin is disabled.
- R9: A multi-byte write that only partly overlaps 0x60..0x63 updates the overlapped route bytes and triggers the rebuild, and it leaves the other route bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pirq_i | input | 4 | PCI interrupt pin levels, bit 0 is pin A |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Write data, byte k goes to cfg_addr+k |
| cfg_wlen | input | 3 | Number of bytes in the write, 0 to 4 |
| cfg_we | input | 1 | Write strobe |
| cfg_re | input | 1 | Read strobe |
| cfg_rdata | output | 8 | Registered read data |
| irq_o | output | 16 | Registered ISA interrupt request lines |
| route_en_o | output | 4 | Per-pin route enabled flag |
| route_irq_o | output | 16 | Per-pin selected IRQ, four bits per pin |

## Verification
On every cycle the assertions check four things. An ISA line rises only when some pin was high. The outputs move only after a pin edge or a rebuild. No pin ever occupies more than one IRQ. A rebuild with every pin disabled leaves all lines low. Only the directed scenarios can show the exact wired-OR values on shared lines, the two-edge latency of a reroute, and the boundary between route values 15 and 16. The same holds for byte placement in partial multi-byte writes and the read-back of the stored route bytes.

// File: rtl/intx_router_pkg.sv
package intx_router_pkg;
    localparam int unsigned BYTE_W = 8;
    typedef logic [BYTE_W-1:0] route_byte_t;
    localparam route_byte_t ROUTE_RESET = 8'h80;
endpackage

// File: rtl/route_regfile.sv
module route_regfile
    import intx_router_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 4,
    parameter int unsigned NUM_IRQ   = 16,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MAX_BYTES = 4,
    parameter logic [ADDR_W-1:0] BASE = 8'h60,
    localparam int unsigned IRQ_W = $clog2(NUM_IRQ),
    localparam int unsigned LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [MAX_BYTES*BYTE_W-1:0] cfg_wdata,
    input  logic [LEN_W-1:0]            cfg_wlen,
    input  logic                        cfg_we,
    input  logic                        cfg_re,
    output logic [BYTE_W-1:0]           cfg_rdata,
    output logic                        rebuild_o,
    output logic [NUM_PINS-1:0]         route_en_o,
    output logic [NUM_PINS-1:0][IRQ_W-1:0] route_irq_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0][BYTE_W-1:0] route;
        logic                            rebuild;
        logic [BYTE_W-1:0]               rdata;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        logic [ADDR_W:0] slot;
        r_d         = r_q;
        r_d.rebuild = 1'b0;
        for (int p = 0; p < NUM_PINS; p++) begin
            slot = {1'b0, BASE} + (ADDR_W+1)'(p);
            if (cfg_we) begin
                for (int k = 0; k < MAX_BYTES; k++) begin
                    if (({1'b0, cfg_addr} + (ADDR_W+1)'(k) == slot) &&
                        (LEN_W'(k) < cfg_wlen)) begin
                        r_d.route[p] = cfg_wdata[k*BYTE_W +: BYTE_W];
                        r_d.rebuild  = 1'b1;
                    end
                end
            end
        end
        if (cfg_re) begin
            r_d.rdata = '0;
            for (int p = 0; p < NUM_PINS; p++) begin
                if ({1'b0, cfg_addr} == {1'b0, BASE} + (ADDR_W+1)'(p))
                    r_d.rdata = r_q.route[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.route   <= {NUM_PINS{ROUTE_RESET}};
            r_q.rebuild <= 1'b0;
            r_q.rdata   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_rdata = r_q.rdata;
    assign rebuild_o = r_q.rebuild;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_status
        assign route_en_o[p]  = (r_q.route[p] < BYTE_W'(NUM_IRQ));
        assign route_irq_o[p] = route_en_o[p] ? r_q.route[p][IRQ_W-1:0] : '0;
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_re) |-> $stable(cfg_rdata)) else $error("rdata moved"); // R3
endmodule

// File: rtl/level_matrix.sv
module level_matrix #(
    parameter int unsigned NUM_PINS = 4,
    parameter int unsigned NUM_IRQ  = 16,
    localparam int unsigned IRQ_W = $clog2(NUM_IRQ)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PINS-1:0]            pirq_i,
    input  logic [NUM_PINS-1:0]            route_en_i,
    input  logic [NUM_PINS-1:0][IRQ_W-1:0] route_irq_i,
    input  logic                           rebuild_i,
    output logic [NUM_IRQ-1:0]             irq_o
);
    typedef struct packed {
        logic [NUM_PINS-1:0][NUM_IRQ-1:0] mat;
        logic [NUM_PINS-1:0]              lvl;
        logic [NUM_IRQ-1:0]               irq;
    } mstate_t;

    mstate_t m_d, m_q;

    always_comb begin
        m_d     = m_q;
        m_d.lvl = pirq_i;
        if (rebuild_i) begin
            m_d.mat = '0;
            for (int p = 0; p < NUM_PINS; p++)
                if (route_en_i[p])
                    m_d.mat[p][route_irq_i[p]] = pirq_i[p];
        end else begin
            for (int p = 0; p < NUM_PINS; p++)
                if (route_en_i[p] && (pirq_i[p] != m_q.lvl[p]))
                    m_d.mat[p][route_irq_i[p]] = pirq_i[p];
        end
        m_d.irq = '0;
        for (int p = 0; p < NUM_PINS; p++)
            m_d.irq = m_d.irq | m_d.mat[p];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) m_q <= '0;
        else        m_q <= m_d;
    end

    assign irq_o = m_q.irq;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_row_chk
        AST_ONE_IRQ_PER_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(m_q.mat[p])) else $error("pin on two IRQs"); // R7
    end

    for (genvar n = 0; n < NUM_IRQ; n++) begin : g_irq_chk
        AST_RISE_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_o[n]) |-> $past(|pirq_i)) else $error("irq rose alone"); // R4
    end

    AST_IRQ_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(irq_o) |-> $past(rebuild_i || (pirq_i != m_q.lvl)))
        else $error("irq moved without cause"); // R5

    AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rebuild_i) && (route_en_i == '0) && ($past(route_en_i) == '0))
        |-> (irq_o == '0)) else $error("disabled pins drive irq"); // R6
endmodule

// File: rtl/intx_irq_router.sv
module intx_irq_router
    import intx_router_pkg::*;
#(
    parameter int unsigned NUM_PINS  = 4,
    parameter int unsigned NUM_IRQ   = 16,
    parameter int unsigned ADDR_W    = 8,
    parameter int unsigned MAX_BYTES = 4,
    parameter logic [ADDR_W-1:0] BASE = 8'h60,
    localparam int unsigned IRQ_W = $clog2(NUM_IRQ),
    localparam int unsigned LEN_W = $clog2(MAX_BYTES + 1)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_PINS-1:0]         pirq_i,
    input  logic [ADDR_W-1:0]           cfg_addr,
    input  logic [MAX_BYTES*BYTE_W-1:0] cfg_wdata,
    input  logic [LEN_W-1:0]            cfg_wlen,
    input  logic                        cfg_we,
    input  logic                        cfg_re,
    output logic [BYTE_W-1:0]           cfg_rdata,
    output logic [NUM_IRQ-1:0]          irq_o,
    output logic [NUM_PINS-1:0]         route_en_o,
    output logic [NUM_PINS*IRQ_W-1:0]   route_irq_o
);
    logic                           rebuild;
    logic [NUM_PINS-1:0][IRQ_W-1:0] route_irq;

    route_regfile #(
        .NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W),
        .MAX_BYTES(MAX_BYTES), .BASE(BASE)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_wlen(cfg_wlen), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_rdata(cfg_rdata), .rebuild_o(rebuild),
        .route_en_o(route_en_o), .route_irq_o(route_irq)
    );

    level_matrix #(.NUM_PINS(NUM_PINS), .NUM_IRQ(NUM_IRQ)) u_mat (
        .clk(clk), .rst_n(rst_n), .pirq_i(pirq_i), .route_en_i(route_en_o),
        .route_irq_i(route_irq), .rebuild_i(rebuild), .irq_o(irq_o)
    );

    assign route_irq_o = route_irq;
endmodule

// File: tb/tb_intx_irq_router.sv
module tb_intx_irq_router;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [3:0]  pirq_i;
    logic [7:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic [2:0]  cfg_wlen;
    logic        cfg_we, cfg_re;
    logic [7:0]  cfg_rdata;
    logic [15:0] irq_o;
    logic [3:0]  route_en_o;
    logic [15:0] route_irq_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    intx_irq_router dut (
        .clk(clk), .rst_n(rst_n), .pirq_i(pirq_i), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_wlen(cfg_wlen), .cfg_we(cfg_we),
        .cfg_re(cfg_re), .cfg_rdata(cfg_rdata), .irq_o(irq_o),
        .route_en_o(route_en_o), .route_irq_o(route_irq_o)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // write presented, then one more edge: rebuild has taken effect
    task automatic wr(logic [7:0] a, logic [31:0] d, logic [2:0] len);
        cfg_addr = a; cfg_wdata = d; cfg_wlen = len; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
        tick();
    endtask

    task automatic rd(logic [7:0] a, output logic [7:0] d);
        cfg_addr = a; cfg_re = 1'b1;
        tick();
        cfg_re = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        check("R1 irq", 32'(irq_o), 0);
        check("R1 en", 32'(route_en_o), 0);
        check("R1 rdata", 32'(cfg_rdata), 0);
        for (int p = 0; p < 4; p++) begin
            rd(8'h60 + 8'(p), d);
            check("R1 route byte", 32'(d), 32'h80);
        end
        pirq_i = 4'hF; tick();
        check("R1 disabled pins silent", 32'(irq_o), 0);
        pirq_i = 4'h0; tick();
    endtask

    task automatic t_share();
        wr(8'h60, 32'h0505, 3'd2);
        check("R8 en shared", 32'(route_en_o), 32'h3);
        check("R8 irq fields", 32'(route_irq_o), 32'h0055);
        pirq_i = 4'b0001; tick();
        check("R5 A rises one edge", 32'(irq_o), 32'h0020);
        pirq_i = 4'b0011; tick();
        check("R4 both high", 32'(irq_o), 32'h0020);
        pirq_i = 4'b0010; tick();
        check("R4 one drops line stays", 32'(irq_o), 32'h0020);
        pirq_i = 4'b0000; tick();
        check("R4 last drops", 32'(irq_o), 0);
    endtask

    task automatic t_reroute();
        wr(8'h60, 32'h03, 3'd1);
        pirq_i = 4'b0001; tick();
        check("R5 irq3 up", 32'(irq_o), 32'h0008);
        cfg_addr = 8'h60; cfg_wdata = 32'h09; cfg_wlen = 3'd1; cfg_we = 1'b1;
        tick();
        cfg_we = 1'b0;
        check("R7 old route held one edge", 32'(irq_o), 32'h0008);
        tick();
        check("R7 moved to irq9", 32'(irq_o), 32'h0200);
        pirq_i = 4'b0000; tick();
        check("R7 new route tracks", 32'(irq_o), 0);
    endtask

    task automatic t_bounds();
        logic [7:0] d;
        wr(8'h60, 32'h0F, 3'd1);
        pirq_i = 4'b0001; tick();
        check("R6 route 15", 32'(irq_o), 32'h8000);
        check("R8 en 15", 32'(route_en_o[0]), 1);
        check("R8 irq 15", 32'(route_irq_o[3:0]), 15);
        wr(8'h60, 32'h10, 3'd1);
        check("R6 route 16 clears", 32'(irq_o), 0);
        check("R8 disabled", {28'b0, route_en_o[0], route_irq_o[2:0]}, 0);
        pirq_i = 4'b0000; tick(); pirq_i = 4'b0001; tick();
        check("R6 route 16 ignored", 32'(irq_o), 0);
        wr(8'h60, 32'h80, 3'd1);
        pirq_i = 4'b0000; tick(); pirq_i = 4'b0001; tick();
        check("R6 route 0x80 ignored", 32'(irq_o), 0);
        rd(8'h60, d);
        check("R3 read 0x80", 32'(d), 32'h80);
        wr(8'h60, 32'h02, 3'd1);
        check("R7 rebuild picks live level", 32'(irq_o), 32'h0004);
        pirq_i = 4'b0000; tick();
    endtask

    task automatic t_overlap();
        logic [7:0] d;
        wr(8'h60, 32'h80808080, 3'd4);
        wr(8'h5F, 32'h0000_0700, 3'd2);
        rd(8'h60, d); check("R9 partial write A", 32'(d), 32'h07);
        rd(8'h61, d); check("R9 B untouched", 32'(d), 32'h80);
        rd(8'h5F, d); check("R3 outside reads 0", 32'(d), 0);
        wr(8'h60, 32'h01, 3'd0);
        rd(8'h60, d); check("R2 len 0 no write", 32'(d), 32'h07);
        wr(8'h63, 32'h0102030B, 3'd4);
        rd(8'h63, d); check("R2 D byte0", 32'(d), 32'h0B);
        rd(8'h64, d); check("R2 beyond discarded", 32'(d), 0);
        check("R8 en after overlap", 32'(route_en_o), 32'h9);
        pirq_i = 4'b1001; tick();
        check("R4 A and D", 32'(irq_o), 32'h0880);
        pirq_i = 4'b0000; tick();
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; pirq_i = '0; cfg_addr = '0; cfg_wdata = '0;
        cfg_wlen = '0; cfg_we = 1'b0; cfg_re = 1'b0;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_share();
        t_reroute();
        t_bounds();
        t_overlap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule